// File: doc/BRIEF.md
# RTC Interrupt Enable and Flag Register

This block keeps the interrupt bookkeeping of a real-time clock. Three event sources (periodic tick, alarm match and end of a time update) each send a one-cycle pulse. Each pulse sets a sticky flag, whether or not that source's interrupt is enabled. A second byte holds the enables. It also holds the mode bits that neighbouring clock logic decodes, including the bit that stops time updates while software loads the time registers.

Software reaches both bytes through a single-cycle access port. A select input picks the enable byte or the flag byte. The top bit of the flag byte is a summary. It reads 1 while any latched flag has its matching enable set, and the active-low interrupt pin follows it. A read of the flag byte returns its current contents and clears every flag on the same clock edge. An event that lands on that edge survives. Writes to the flag byte change nothing.

Top module: `rtcirq_ctl`

## Requirements
- R1: After reset the enable byte reads 0x00, the flag byte reads 0x00, `halt_upd` is 0 and `irq_n` is 1.
- R2: A write with `acc_sel`=0 loads `acc_wdata` into the enable byte. From the next cycle it reads back unchanged and appears on `ctl_bits`. `halt_upd` equals bit 7 of the enable byte.
- R3: Periodic, alarm and update pulses set flag byte bits 6, 5 and 4 respectively, whatever the enables hold. Bits 3..0 of the flag byte always read 0.
- R4: Bit 7 of the flag byte reads 1 exactly when a flag at bit 6, 5 or 4 is set together with enable byte bit 6, 5 or 4 at the same position.
- R5: `irq_n` is 0 exactly while bit 7 of the flag byte would read 1.
- R6: A read with `acc_sel`=1 returns the flag byte as it stood before the access. From the next cycle, flags 6..4 and bit 7 are 0, unless a new event arrived.
- R7: An event pulse in the same cycle as a flag-byte read is set in the flag byte afterwards. It is absent from the data that read returns.
- R8: A write with `acc_sel`=1 leaves the flag byte and `irq_n` unchanged.
- R9: A read of the enable byte leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_periodic | input | 1 | Periodic event pulse |
| ev_alarm | input | 1 | Alarm event pulse |
| ev_update | input | 1 | Update-ended event pulse |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = enable byte, 1 = flag byte |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid in the access cycle; 0 otherwise |
| ctl_bits | output | 8 | Current enable byte for neighbouring logic |
| halt_upd | output | 1 | Stop time updates (enable byte bit 7) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The main sweep takes every combination of the three enables with every combination of the three event pulses. It checks the summary bit and the pin against the AND-then-OR of the two masks. This separates a summary that ignores the enables from one that ignores the flags. A read, then a second read, tells a true clear from a stale value. Targeted cases place an event on the clearing edge and write 0xFF and 0x00 to the flag byte. They also read the enable byte while flags are pending. Each case catches a different wrong clear or wrong write decode.

// File: rtl/rtcirq_pkg.sv
package rtcirq_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned NUM_SRC = 3;
    // source index i maps to bit SRC_LSB+i in both bytes
    localparam int unsigned SRC_LSB  = 4;
    localparam int unsigned SUM_BIT  = REG_W - 1;
    localparam int unsigned HALT_BIT = REG_W - 1;

    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_FLAGS  = 1'b1
    } reg_sel_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [REG_W-1:0]   reg_t;
endpackage

// File: rtl/rtcirq_enable_reg.sv
module rtcirq_enable_reg
    import rtcirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  reg_t wdata,
    output reg_t en_q
);
    typedef struct packed {
        reg_t bits;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.bits = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q = st_q.bits;
endmodule

// File: rtl/rtcirq_flag_bank.sv
module rtcirq_flag_bank
    import rtcirq_pkg::*;
#(
    parameter int unsigned N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         clr,
    output logic [N-1:0] flag_q
);
    typedef struct packed {
        logic [N-1:0] flags;
    } fl_state_t;

    fl_state_t st_d, st_q;

    // a new pulse wins over the clear on the same edge
    for (genvar i = 0; i < N; i++) begin : g_src
        always_comb begin
            st_d.flags[i] = ev[i] | (st_q.flags[i] & ~clr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q = st_q.flags;
endmodule

// File: rtl/rtcirq_summary.sv
module rtcirq_summary
    import rtcirq_pkg::*;
#(
    parameter int unsigned N = NUM_SRC
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    output logic         sum,
    output logic         irq_n
);
    logic [N-1:0] qual;

    always_comb begin
        qual  = flags & enables;
        sum   = |qual;
        irq_n = ~sum;
    end
endmodule

// File: rtl/rtcirq_ctl.sv
module rtcirq_ctl
    import rtcirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_periodic,
    input  logic       ev_alarm,
    input  logic       ev_update,
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic       acc_sel,
    input  logic [7:0] acc_wdata,
    output logic [7:0] acc_rdata,
    output logic [7:0] ctl_bits,
    output logic       halt_upd,
    output logic       irq_n
);
    src_vec_t ev_vec;
    src_vec_t flag_q;
    src_vec_t en_src;
    reg_t     en_q;
    logic     sum;
    logic     en_wr;
    logic     fl_rd;

    always_comb begin
        ev_vec = {ev_periodic, ev_alarm, ev_update};
        en_wr  = acc_valid & acc_write & (reg_sel_e'(acc_sel) == SEL_ENABLE);
        fl_rd  = acc_valid & ~acc_write & (reg_sel_e'(acc_sel) == SEL_FLAGS);
        en_src = en_q[SRC_LSB +: NUM_SRC];
    end

    rtcirq_enable_reg u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (en_wr),
        .wdata (acc_wdata),
        .en_q  (en_q)
    );

    rtcirq_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_vec),
        .clr    (fl_rd),
        .flag_q (flag_q)
    );

    rtcirq_summary #(.N(NUM_SRC)) u_sum (
        .flags   (flag_q),
        .enables (en_src),
        .sum     (sum),
        .irq_n   (irq_n)
    );

    always_comb begin
        acc_rdata = '0;
        if (acc_valid && !acc_write) begin
            if (reg_sel_e'(acc_sel) == SEL_ENABLE) begin
                acc_rdata = en_q;
            end else begin
                acc_rdata[SUM_BIT]            = sum;
                acc_rdata[SRC_LSB +: NUM_SRC] = flag_q;
            end
        end
        ctl_bits = en_q;
        halt_upd = en_q[HALT_BIT];
    end
endmodule

// File: rtl/rtcirq_ctl_chk.sv
module rtcirq_ctl_chk
    import rtcirq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] ev,
    input logic       acc_valid,
    input logic       acc_write,
    input logic       acc_sel,
    input logic [7:0] acc_wdata,
    input logic [7:0] ctl_bits,
    input logic       irq_n,
    input logic [2:0] flag_vec
);
    logic en_write, fl_write, fl_read, en_read;

    always_comb begin
        en_write = acc_valid && acc_write && !acc_sel;
        fl_write = acc_valid && acc_write && acc_sel;
        fl_read  = acc_valid && !acc_write && acc_sel;
        en_read  = acc_valid && !acc_write && !acc_sel;
    end

    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        en_write |=> ctl_bits == $past(acc_wdata)); // R2

    AST_EVENT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[2] && ctl_bits[6] && !en_write) |=> !irq_n); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_read && ev == 3'b000) |=> (irq_n && flag_vec == 3'b000)); // R6

    AST_COINCIDENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_read && ev[1]) |=> flag_vec[1]); // R7

    AST_FLAG_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_write && ev == 3'b000) |=> $stable(flag_vec)); // R8

    AST_EN_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_read && ev == 3'b000) |=> $stable(flag_vec)); // R9
endmodule

bind rtcirq_ctl rtcirq_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        ({ev_periodic, ev_alarm, ev_update}),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_sel   (acc_sel),
    .acc_wdata (acc_wdata),
    .ctl_bits  (ctl_bits),
    .irq_n     (irq_n),
    .flag_vec  (flag_q)
);

// File: tb/rtcirq_ctl_tb.sv
module rtcirq_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_periodic = 1'b0, ev_alarm = 1'b0, ev_update = 1'b0;
    logic       acc_valid = 1'b0, acc_write = 1'b0, acc_sel = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata, ctl_bits;
    logic       halt_upd, irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rtcirq_ctl u_dut (
        .clk(clk), .rst_n(rst_n),
        .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_update(ev_update),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .ctl_bits(ctl_bits), .halt_upd(halt_upd), .irq_n(irq_n)
    );

    task automatic cyc;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        acc_valid = 1; acc_write = 1; acc_sel = sel; acc_wdata = d;
        cyc();
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic rd(input logic sel, input logic [2:0] ev, output logic [7:0] d);
        acc_valid = 1; acc_write = 0; acc_sel = sel;
        {ev_periodic, ev_alarm, ev_update} = ev;
        #1 d = acc_rdata;
        cyc();
        acc_valid = 0;
        {ev_periodic, ev_alarm, ev_update} = 3'b000;
    endtask

    task automatic pulse(input logic [2:0] ev);
        {ev_periodic, ev_alarm, ev_update} = ev;
        cyc();
        {ev_periodic, ev_alarm, ev_update} = 3'b000;
    endtask

    function automatic logic [7:0] flag_byte(input logic [2:0] fl, input logic [2:0] en);
        return {|(fl & en), fl, 4'b0000};
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk({7'b0, irq_n}, 8'h01, "R1 irq_n");
        chk({7'b0, halt_upd}, 8'h00, "R1 halt_upd");
        rd(1'b0, 3'b000, d); chk(d, 8'h00, "R1 enable byte");
        rd(1'b1, 3'b000, d); chk(d, 8'h00, "R1 flag byte");

        // R2 enable write/readback and halt bit
        wr(1'b0, 8'h80);
        chk(ctl_bits, 8'h80, "R2 ctl_bits");
        chk({7'b0, halt_upd}, 8'h01, "R2 halt_upd set");
        wr(1'b0, 8'h0B);
        rd(1'b0, 3'b000, d); chk(d, 8'h0B, "R2 readback");
        chk({7'b0, halt_upd}, 8'h00, "R2 halt_upd clear");

        // sweep: every enable mask against every event mask (R3 R4 R5 R6)
        for (int e = 0; e < 8; e++) begin
            for (int f = 0; f < 8; f++) begin
                logic [7:0] en_byte;
                logic [7:0] exp;
                en_byte = {1'b0, e[2:0], f[3:0] ^ 4'h5};
                wr(1'b0, en_byte);
                chk(ctl_bits, en_byte, "R2 sweep ctl_bits");
                pulse(f[2:0]);
                exp = flag_byte(f[2:0], e[2:0]);
                chk({7'b0, irq_n}, {7'b0, ~exp[7]}, "R5 sweep irq_n");
                rd(1'b1, 3'b000, d);
                chk(d, exp, "R3 R4 sweep flag byte");
                chk({7'b0, irq_n}, 8'h01, "R6 irq_n after clear");
                rd(1'b1, 3'b000, d);
                chk(d, 8'h00, "R6 second read");
            end
        end

        // R4 enable raised after flag already latched
        wr(1'b0, 8'h00);
        pulse(3'b001);
        chk({7'b0, irq_n}, 8'h01, "R4 masked flag no irq");
        wr(1'b0, 8'h10);
        chk({7'b0, irq_n}, 8'h00, "R4 late enable irq");
        rd(1'b1, 3'b000, d); chk(d, 8'h90, "R4 late enable byte");

        // R7 coincident event on read-clear
        wr(1'b0, 8'h70);
        pulse(3'b010);
        rd(1'b1, 3'b001, d); chk(d, 8'hA0, "R7 data of clearing read");
        chk({7'b0, irq_n}, 8'h00, "R7 irq kept");
        rd(1'b1, 3'b000, d); chk(d, 8'h90, "R7 coincident update kept");

        // R8 writes to flag byte ignored
        wr(1'b1, 8'hFF);
        chk({7'b0, irq_n}, 8'h01, "R8 irq_n after 0xFF write");
        rd(1'b1, 3'b000, d); chk(d, 8'h00, "R8 no flags from write");
        pulse(3'b100);
        wr(1'b1, 8'h00);
        chk({7'b0, irq_n}, 8'h00, "R8 irq_n after 0x00 write");
        rd(1'b1, 3'b000, d); chk(d, 8'hC0, "R8 flag kept");

        // R9 enable reads do not clear flags
        pulse(3'b010);
        rd(1'b0, 3'b000, d); chk(d, 8'h70, "R9 enable read value");
        rd(1'b0, 3'b000, d);
        rd(1'b1, 3'b000, d); chk(d, 8'hA0, "R9 flag survives");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule